// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serializes bytes (or 9-bit words) onto a single NRZ line. Every frame has a low start bit, then the data bits with the least-significant bit first, then a high stop bit. The hardware adds no parity. A one-entry holding buffer sits in front of the shift register. Software can therefore queue the next word while the current frame is still on the line. The word moves into the shifter only after the stop bit of the frame in progress has ended.

Bit timing comes from an external divider that supplies a one-clock `bitTick` pulse per bit period. Two flags report where the data is. A buffer-empty flag, which can also raise an interrupt request, tells software when it may write again. A shift-empty status bit shows that the line has gone idle, and it has no interrupt. In 9-bit mode a ninth data bit is sent after bit 7. It can carry an address/data marker or a parity bit that software computes.

Top module: `dblBufSerialTx`

## Requirements
- R1: Each bit of a frame lasts one `bitTick` period. `serialOut` is high when idle. The frame is a start bit of 0, then data bits from bit 0 upward, then a stop bit of 1. The start bit appears on the first tick edge after the shifter is loaded.
- R2: When `mode9` is 1 at the moment of loading, the frame carries a ninth data bit after bit 7. Its value is `wrBit9` as captured with the write. When `mode9` is 0, the frame has 8 data bits.
- R3: The shifter takes the buffered word on the clock after it becomes empty. It becomes empty one clock after the tick that ends the stop bit. While a frame is shifting, a buffered word waits.
- R4: `bufEmpty` cannot be cleared except by a write. After a write sampled at edge k, the flag is still unchanged after edge k and reads 0 after edge k+1. The flag reads 1 again one clock after the word moves into the shifter.
- R5: `irqReq` is high exactly when both `bufEmpty` and `irqEnable` are high. `irqEnable` has no effect on `bufEmpty`.
- R6: While `txEnable` is 0, writes are ignored, `serialOut` is 1, `shiftEmpty` is 1 and `bufEmpty` is 0. A frame in progress is aborted. The clock after `txEnable` is sampled high, `bufEmpty` reads 1.
- R7: `shiftEmpty` is 1 exactly when no frame is loaded in the shifter.
- R8: A write while the buffer already holds a word replaces that word and sets `overwriteFlag`. This does not apply to a write in the same clock as the transfer to the shifter. `overwriteFlag` stays set until `txEnable` goes low.
- R9: After reset, `serialOut`=1, `bufEmpty`=0, `shiftEmpty`=1, `irqReq`=0 and `overwriteFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmitter enable; low aborts and clears |
| mode9 | input | 1 | 1 selects 9 data bits per frame |
| irqEnable | input | 1 | Lets `bufEmpty` drive `irqReq` |
| wrStrobe | input | 1 | One-clock write into the holding buffer |
| wrData | input | DATA_W | Data word to send |
| wrBit9 | input | 1 | Ninth data bit, captured with the write |
| bitTick | input | 1 | One-clock pulse per bit period |
| serialOut | output | 1 | Serial line |
| bufEmpty | output | 1 | Holding buffer can accept a word |
| irqReq | output | 1 | Interrupt request from `bufEmpty` |
| shiftEmpty | output | 1 | Shifter holds no frame |
| overwriteFlag | output | 1 | Sticky: a buffered word was overwritten |

## Verification
Some rules are checked by assertions on every cycle:
- The line is high whenever the shifter is empty.
- The interrupt request never appears without the empty flag.
- The empty flag falls only two clocks after a write, or after a disable.
- The flag rises on enable.
- The overwrite indicator rises only on a write into a full buffer.

Other behaviour only the bench scenarios can show:
- The bit order and content of whole 8-bit and 9-bit frames on the line.
- That the buffered word waits for the previous stop bit.
- That the overwritten word is never sent.
- That a write made while disabled never produces a frame.

// File: rtl/dblTxPkg.sv
package dblTxPkg;
  typedef struct packed {
    logic capture;  // latch write data into holding buffer
    logic load;     // move holding buffer into frame shifter
    logic shift;    // present next frame bit on the line
    logic clear;    // abort: idle the line and flush the shifter
  } txStrobe_t;
endpackage

// File: rtl/dblTxCtrl.sv
module dblTxCtrl
  import dblTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       mode9,
  input  logic       wrStrobe,
  input  logic       bitTick,
  output txStrobe_t  strobes,
  output logic       bufEmpty,
  output logic       shiftEmpty,
  output logic       overwriteFlag
);
  localparam int LEN_LONG  = DATA_W + 3;
  localparam int LEN_SHORT = DATA_W + 2;
  localparam int CNT_W     = $clog2(LEN_LONG + 1);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LEN_LONG);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(LEN_SHORT);

  logic             holdFull;
  logic             busy;
  logic [CNT_W-1:0] bitsLeft;
  logic             loadNow, writeOk, shiftNow, finishNow;

  assign loadNow   = txEnable & holdFull & ~busy;
  assign writeOk   = txEnable & wrStrobe;
  assign shiftNow  = txEnable & busy & bitTick & (bitsLeft != '0);
  assign finishNow = txEnable & busy & bitTick & (bitsLeft == '0);

  always_comb begin
    strobes.capture = writeOk;
    strobes.load    = loadNow;
    strobes.shift   = shiftNow;
    strobes.clear   = ~txEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull      <= 1'b0;
      busy          <= 1'b0;
      bitsLeft      <= '0;
      bufEmpty      <= 1'b0;
      overwriteFlag <= 1'b0;
    end else if (!txEnable) begin
      holdFull      <= 1'b0;
      busy          <= 1'b0;
      bitsLeft      <= '0;
      bufEmpty      <= 1'b0;
      overwriteFlag <= 1'b0;
    end else begin
      bufEmpty <= ~holdFull;
      if (loadNow) begin
        busy     <= 1'b1;
        bitsLeft <= mode9 ? LEN_L : LEN_S;
      end else if (shiftNow) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end else if (finishNow) begin
        busy <= 1'b0;
      end
      if (writeOk) holdFull <= 1'b1;
      else if (loadNow) holdFull <= 1'b0;
      if (writeOk && holdFull && !loadNow) overwriteFlag <= 1'b1;
    end
  end

  assign shiftEmpty = ~busy;

  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> (bitsLeft == '0));

  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= LEN_L);

  // R4
  buf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> ($past(wrStrobe, 2) || !$past(txEnable)));

  // R8
  overwrite_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overwriteFlag) |-> $past(wrStrobe && holdFull));
endmodule

// File: rtl/dblTxData.sv
module dblTxData
  import dblTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobes,
  input  logic              mode9,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrBit9,
  output logic              serialOut
);
  localparam int FRAME_W = DATA_W + 3;

  logic [DATA_W:0]    holdData;
  logic [FRAME_W-1:0] frameReg;
  logic               lineOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      frameReg <= '1;
      lineOut  <= 1'b1;
    end else begin
      if (strobes.capture) holdData <= {wrBit9, wrData};
      if (strobes.clear) begin
        frameReg <= '1;
        lineOut  <= 1'b1;
      end else if (strobes.load) begin
        frameReg <= {1'b1, (mode9 ? holdData[DATA_W] : 1'b1),
                     holdData[DATA_W-1:0], 1'b0};
      end else if (strobes.shift) begin
        lineOut  <= frameReg[0];
        frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
      end
    end
  end

  assign serialOut = lineOut;

  // R1
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> serialOut);

  // R6
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> serialOut);
endmodule

// File: rtl/dblBufSerialTx.sv
module dblBufSerialTx
  import dblTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              mode9,
  input  logic              irqEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrBit9,
  input  logic              bitTick,
  output logic              serialOut,
  output logic              bufEmpty,
  output logic              irqReq,
  output logic              shiftEmpty,
  output logic              overwriteFlag
);
  txStrobe_t strobes;

  dblTxCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .mode9(mode9),
    .wrStrobe(wrStrobe), .bitTick(bitTick), .strobes(strobes),
    .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty),
    .overwriteFlag(overwriteFlag));

  dblTxData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mode9(mode9),
    .wrData(wrData), .wrBit9(wrBit9), .serialOut(serialOut));

  assign irqReq = bufEmpty & irqEnable;

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> serialOut);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> bufEmpty);

  // R6
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |=> bufEmpty);

  // R6
  disabled_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (shiftEmpty && serialOut && !bufEmpty));
endmodule

// File: tb/dblBufSerialTx_tb.sv
`timescale 1ns/1ps
module dblBufSerialTx_tb;
  localparam int DATA_W   = 8;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, mode9 = 1'b0, irqEnable = 1'b0;
  logic wrStrobe = 1'b0, wrBit9 = 1'b0, bitTick = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic serialOut, bufEmpty, irqReq, shiftEmpty, overwriteFlag;

  int nChecks = 0, nErr = 0, cyc = 0, tickCnt = 0;
  logic tickPrev = 1'b0;
  bit capQ[$];

  // reference model state
  bit mHoldFull = 0, mBusy = 0, mLine = 1, mBufEmpty = 0, mOvw = 0;
  int mHoldData = 0;
  bit mHold9 = 0;
  bit mBits[$];

  always #2.5 clk = ~clk;

  dblBufSerialTx #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .mode9(mode9),
    .irqEnable(irqEnable), .wrStrobe(wrStrobe), .wrData(wrData),
    .wrBit9(wrBit9), .bitTick(bitTick), .serialOut(serialOut),
    .bufEmpty(bufEmpty), .irqReq(irqReq), .shiftEmpty(shiftEmpty),
    .overwriteFlag(overwriteFlag));

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bit-rate tick source
  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    bitTick <= (tickCnt == TICK_DIV - 1);
  end

  // behavioural reference, advanced at each clock edge
  always @(posedge clk) begin
    tickPrev <= bitTick;
    if (!rstN || !txEnable) begin
      mHoldFull = 0; mBusy = 0; mLine = 1; mBufEmpty = 0; mOvw = 0;
      mBits.delete();
    end else begin
      bit oldFull, takeNow;
      oldFull = mHoldFull;
      takeNow = mHoldFull && !mBusy;
      if (mBusy && bitTick) begin
        if (mBits.size() > 0) mLine = mBits.pop_front();
        else mBusy = 0;
      end
      if (takeNow) begin
        mBits.push_back(1'b0);
        for (int i = 0; i < DATA_W; i++) mBits.push_back(mHoldData[i]);
        if (mode9) mBits.push_back(mHold9);
        mBits.push_back(1'b1);
        mBusy = 1; mHoldFull = 0;
      end
      if (wrStrobe) begin
        if (mHoldFull) mOvw = 1;
        mHoldData = wrData; mHold9 = wrBit9; mHoldFull = 1;
      end
      mBufEmpty = !oldFull;
    end
  end

  // per-cycle comparison and line capture (inputs change later, at +1ns)
  always @(negedge clk) begin
    if (rstN) begin
      check("R1 line", serialOut, mLine);
      check("R4 bufEmpty", bufEmpty, mBufEmpty);
      check("R5 irqReq", irqReq, mBufEmpty && irqEnable);
      check("R7 shiftEmpty", shiftEmpty, !mBusy);
      check("R8 overwrite", overwriteFlag, mOvw);
      if (tickPrev) capQ.push_back(serialOut);
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(int data, bit b9);
    @(negedge clk); #1;
    wrStrobe = 1'b1; wrData = DATA_W'(data); wrBit9 = b9;
    @(negedge clk); #1;
    wrStrobe = 1'b0;
  endtask

  task automatic expectFrame(string req, int data, bit nine, bit b9);
    int got, exp, nb;
    bit stopBit;
    while (capQ.size() > 0 && capQ[0] == 1'b1) void'(capQ.pop_front());
    nb = DATA_W + (nine ? 1 : 0);
    if (capQ.size() < nb + 2) begin
      check({req, " frame present"}, capQ.size(), nb + 2);
      return;
    end
    void'(capQ.pop_front());
    got = 0;
    for (int i = 0; i < nb; i++) if (capQ.pop_front()) got |= (1 << i);
    stopBit = capQ.pop_front();
    exp = data | (nine ? (int'(b9) << DATA_W) : 0);
    check({req, " data"}, got, exp);
    check({req, " stop"}, stopBit, 1);
  endtask

  initial begin
    waitCycles(3);
    // R9 reset state
    check("R9 serialOut", serialOut, 1);
    check("R9 bufEmpty", bufEmpty, 0);
    check("R9 shiftEmpty", shiftEmpty, 1);
    check("R9 irqReq", irqReq, 0);
    check("R9 overwrite", overwriteFlag, 0);
    @(negedge clk); #1; rstN = 1'b1;
    waitCycles(2);

    // R6 enable sets the flag; R5 gating
    @(negedge clk); #1; txEnable = 1'b1;
    @(negedge clk);
    check("R6 enable sets bufEmpty", bufEmpty, 1);
    check("R5 irq masked", irqReq, 0);
    #1; irqEnable = 1'b1;
    @(negedge clk);
    check("R5 irq enabled", irqReq, 1);

    // R4 flag timing, R1 frame content
    capQ.delete();
    doWrite(8'hA5, 1'b0);
    check("R4 unchanged after write edge", bufEmpty, 1);
    @(negedge clk);
    check("R4 cleared second clock", bufEmpty, 0);
    check("R7 shifter loaded", shiftEmpty, 0);
    @(negedge clk);
    check("R4 set after transfer", bufEmpty, 1);
    waitCycles(70);
    expectFrame("R1 8-bit frame", 8'hA5, 1'b0, 1'b0);
    check("R7 idle after frame", shiftEmpty, 1);

    // R2 nine-bit frame
    @(negedge clk); #1; mode9 = 1'b1;
    capQ.delete();
    doWrite(8'h3C, 1'b1);
    waitCycles(75);
    expectFrame("R2 9-bit frame", 8'h3C, 1'b1, 1'b1);
    @(negedge clk); #1; mode9 = 1'b0;

    // R3 waiting word, R8 overwrite
    capQ.delete();
    doWrite(8'h81, 1'b0);
    waitCycles(6);
    doWrite(8'h42, 1'b0);
    waitCycles(3);
    check("R3 word waits while shifting", bufEmpty, 0);
    check("R8 no overwrite yet", overwriteFlag, 0);
    doWrite(8'h5E, 1'b0);
    @(negedge clk);
    check("R8 overwrite set", overwriteFlag, 1);
    waitCycles(140);
    expectFrame("R3 first frame", 8'h81, 1'b0, 1'b0);
    expectFrame("R8 replacing word sent", 8'h5E, 1'b0, 1'b0);
    check("R8 overwrite sticky", overwriteFlag, 1);

    // R6 abort mid-frame and ignored write
    doWrite(8'h00, 1'b0);
    waitCycles(20);
    @(negedge clk); #1; txEnable = 1'b0;
    waitCycles(2);
    check("R6 line idle on abort", serialOut, 1);
    check("R6 shifter flushed", shiftEmpty, 1);
    check("R6 bufEmpty low disabled", bufEmpty, 0);
    check("R6 overwrite cleared", overwriteFlag, 0);
    doWrite(8'h00, 1'b0);
    @(negedge clk); #1; txEnable = 1'b1;
    capQ.delete();
    waitCycles(80);
    check("R6 ignored write not sent", shiftEmpty, 1);
    begin
      int zeros = 0;
      foreach (capQ[i]) if (!capQ[i]) zeros++;
      check("R6 line stayed high", zeros, 0);
    end
    check("R6 flag after re-enable", bufEmpty, 1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule